// File: doc/BRIEF.md
# Snooping Write-Invalidate Line Controller

This block manages the coherence of one cache line in a private cache that sits on a shared snooping bus. It serves the local processor's reads and writes. It watches the transactions other caches place on the bus. It keeps the line's address tag, its state (invalid, clean-shared or dirty-modified) and its data word up to date. The `WRITE_BACK` parameter selects the policy. With write-through, every local write goes to memory. With write-back, writes stay in the line until the line is evicted or another cache asks for it.

Bus transactions take one cycle each. A transaction carries a valid bit, a two-bit kind, an address and a data word. The kind codes are 0 for a read miss, 1 for an invalidate and 2 for a memory write. A memory write also removes other copies of its address. During a read miss the system places the returned word on `bus_rdata`. That word comes from memory, or from a dirty owner that raises `sup_valid`; memory takes that supplied value in the same cycle. Read results come back one cycle after the read is accepted. Arbitration between caches is outside the block: two controllers and a memory register are connected together around it.

Top module: `snp_line_ctrl`

## Requirements
- R1: After reset the line is invalid, `req_ready` is 1, and `bo_valid`, `rsp_valid` and `sup_valid` are 0.
- R2: An accepted read whose address misses (line invalid or different tag) drives `bo_valid`=1, `bo_kind`=0 and `bo_addr`=request address in the same cycle. The next cycle returns `rsp_valid`=1 with the `bus_rdata` value, and the line then holds that value clean.
- R3: A read that hits (line valid, same tag) places no bus transaction and returns the cached word one cycle later.
- R4: With write-through, every local write drives `bo_kind`=2 carrying the write address and data in the same cycle, memory takes that data, and the line holds it clean. Write-through never supplies data and never stalls.
- R5: With write-back, a write to an address the line does not hold modified drives `bo_kind`=1 for that address and leaves the line modified. A write to the modified line at its own address places no bus transaction.
- R6: A snooped kind 1 or kind 2 transaction for the held address makes the line invalid. This also applies to a modified line, which is dropped with no write-back, so the next local read of that address misses.
- R7: A snooped read miss for the address of a modified line raises `sup_valid` with the line's data in the same cycle, and the line becomes clean-shared. A following local write to it issues an invalidate again.
- R8: With write-back, a request to a different address while the line is modified holds `req_ready`=0 for one cycle. In that cycle it drives `bo_kind`=2 with the old tag and data, and the request completes in the next cycle.
- R9: A snooped transaction for another address, or while the line is invalid, changes nothing and supplies nothing.
- R10: A snooped read miss for the address of a clean-shared line leaves the line valid and supplies nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Local request address |
| req_wdata | input | DATA_W | Local write data |
| req_ready | output | 1 | Request completes this cycle |
| rsp_valid | output | 1 | Read result valid |
| rsp_data | output | DATA_W | Read result |
| bo_valid | output | 1 | This cache drives a bus transaction |
| bo_kind | output | 2 | 0 read miss, 1 invalidate, 2 memory write |
| bo_addr | output | ADDR_W | Transaction address |
| bo_data | output | DATA_W | Data for a memory write |
| bus_rdata | input | DATA_W | Word returned for this cache's read miss |
| sn_valid | input | 1 | Another cache's transaction is on the bus |
| sn_kind | input | 2 | Kind of the snooped transaction |
| sn_addr | input | ADDR_W | Address of the snooped transaction |
| sup_valid | output | 1 | This cache supplies dirty data for a snooped miss |
| sup_data | output | DATA_W | Supplied word |

## Verification
The assertions rely on the system never giving the block a local request and a snooped transaction in the same cycle. That is the job of the bus arbiter. They also rely on a stalled request being presented again in the next cycle. The bench keeps to both rules: each step activates at most one cache, the other cache of the pair only snoops, and a request that the reference model predicts will stall is driven again unchanged. A write-through pair and a write-back pair are driven in turn through the same two-processor sequence. That sequence covers misses served from memory and from a dirty owner, dropping a modified line, eviction of a dirty victim, and snoops to other addresses.

// File: rtl/snp_pkg.sv
package snp_pkg;
   typedef enum logic [1:0] {
      BUS_RDMISS = 2'd0,
      BUS_INVAL  = 2'd1,
      BUS_WRMEM  = 2'd2
   } bus_kind_e;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_MOD = 2'd2
   } line_st_e;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
   import snp_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  line_st_e          nxt_st,
   input  logic [ADDR_W-1:0] nxt_tag,
   input  logic [DATA_W-1:0] nxt_data,
   output line_st_e          st,
   output logic [ADDR_W-1:0] tag,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= LN_INV;
         tag  <= '0;
         data <= '0;
      end else if (upd) begin
         st   <= nxt_st;
         tag  <= nxt_tag;
         data <= nxt_data;
      end
   end
endmodule

// File: rtl/snp_local_side.sv
module snp_local_side
   import snp_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  line_st_e          st,
   input  logic [ADDR_W-1:0] tag,
   input  logic [DATA_W-1:0] data,
   output logic              ready,
   output logic              bo_valid,
   output bus_kind_e         bo_kind,
   output logic [ADDR_W-1:0] bo_addr,
   output logic [DATA_W-1:0] bo_data,
   output logic              upd,
   output line_st_e          nst,
   output logic [ADDR_W-1:0] ntag,
   output logic [DATA_W-1:0] ndata,
   output logic              rd_accept,
   output logic [DATA_W-1:0] rd_value
);
   logic      hit;
   logic      victim;
   logic      wr_bus;
   bus_kind_e wr_kind;
   line_st_e  wr_st;

   assign hit = (st != LN_INV) && (tag == req_addr);

   generate
      if (WRITE_BACK) begin : g_wback
         assign victim  = (st == LN_MOD) && (tag != req_addr);
         assign wr_bus  = !((st == LN_MOD) && hit);
         assign wr_kind = BUS_INVAL;
         assign wr_st   = LN_MOD;
      end else begin : g_wthru
         assign victim  = 1'b0;
         assign wr_bus  = 1'b1;
         assign wr_kind = BUS_WRMEM;
         assign wr_st   = LN_SHR;
      end
   endgenerate

   always_comb begin
      ready     = 1'b1;
      bo_valid  = 1'b0;
      bo_kind   = BUS_RDMISS;
      bo_addr   = req_addr;
      bo_data   = req_wdata;
      upd       = 1'b0;
      nst       = st;
      ntag      = tag;
      ndata     = data;
      rd_accept = 1'b0;
      rd_value  = data;
      if (req_valid) begin
         if (victim) begin
            ready    = 1'b0;
            bo_valid = 1'b1;
            bo_kind  = BUS_WRMEM;
            bo_addr  = tag;
            bo_data  = data;
            upd      = 1'b1;
            nst      = LN_SHR;
         end else if (!req_write) begin
            rd_accept = 1'b1;
            if (!hit) begin
               bo_valid = 1'b1;
               bo_kind  = BUS_RDMISS;
               upd      = 1'b1;
               nst      = LN_SHR;
               ntag     = req_addr;
               ndata    = bus_rdata;
               rd_value = bus_rdata;
            end
         end else begin
            bo_valid = wr_bus;
            bo_kind  = wr_kind;
            upd      = 1'b1;
            nst      = wr_st;
            ntag     = req_addr;
            ndata    = req_wdata;
         end
      end
   end
endmodule

// File: rtl/snp_snoop_side.sv
module snp_snoop_side
   import snp_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              sn_valid,
   input  logic [1:0]        sn_kind,
   input  logic [ADDR_W-1:0] sn_addr,
   input  line_st_e          st,
   input  logic [ADDR_W-1:0] tag,
   input  logic [DATA_W-1:0] data,
   output logic              sup_valid,
   output logic [DATA_W-1:0] sup_data,
   output logic              upd,
   output line_st_e          nst
);
   logic match;

   assign match    = sn_valid && (st != LN_INV) && (sn_addr == tag);
   assign sup_data = data;

   always_comb begin
      sup_valid = 1'b0;
      upd       = 1'b0;
      nst       = st;
      if (match) begin
         if (sn_kind == BUS_RDMISS) begin
            if (st == LN_MOD) begin
               sup_valid = 1'b1;
               upd       = 1'b1;
               nst       = LN_SHR;
            end
         end else if (sn_kind == BUS_INVAL || sn_kind == BUS_WRMEM) begin
            upd = 1'b1;
            nst = LN_INV;
         end
      end
   end
endmodule

// File: rtl/snp_line_ctrl.sv
module snp_line_ctrl
   import snp_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              bo_valid,
   output logic [1:0]        bo_kind,
   output logic [ADDR_W-1:0] bo_addr,
   output logic [DATA_W-1:0] bo_data,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              sn_valid,
   input  logic [1:0]        sn_kind,
   input  logic [ADDR_W-1:0] sn_addr,
   output logic              sup_valid,
   output logic [DATA_W-1:0] sup_data
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("snp_line_ctrl: ADDR_W and DATA_W must be at least 1");
      end
   endgenerate

   line_st_e          st, loc_st, snp_st, nxt_st;
   logic [ADDR_W-1:0] tag, loc_tag, nxt_tag;
   logic [DATA_W-1:0] data, loc_data, nxt_data, rd_value;
   logic              loc_upd, snp_upd, nxt_upd, rd_accept;
   bus_kind_e         bo_kind_e;

   snp_local_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_BACK(WRITE_BACK)) i_local (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .bus_rdata (bus_rdata),
      .st        (st),
      .tag       (tag),
      .data      (data),
      .ready     (req_ready),
      .bo_valid  (bo_valid),
      .bo_kind   (bo_kind_e),
      .bo_addr   (bo_addr),
      .bo_data   (bo_data),
      .upd       (loc_upd),
      .nst       (loc_st),
      .ntag      (loc_tag),
      .ndata     (loc_data),
      .rd_accept (rd_accept),
      .rd_value  (rd_value)
   );

   assign bo_kind = bo_kind_e;

   snp_snoop_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_snoop (
      .sn_valid  (sn_valid),
      .sn_kind   (sn_kind),
      .sn_addr   (sn_addr),
      .st        (st),
      .tag       (tag),
      .data      (data),
      .sup_valid (sup_valid),
      .sup_data  (sup_data),
      .upd       (snp_upd),
      .nst       (snp_st)
   );

   // Local and snooped activity never share a cycle; local wins if they do.
   always_comb begin
      nxt_upd  = loc_upd || snp_upd;
      nxt_st   = loc_upd ? loc_st   : snp_st;
      nxt_tag  = loc_upd ? loc_tag  : tag;
      nxt_data = loc_upd ? loc_data : data;
   end

   snp_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (nxt_upd),
      .nxt_st   (nxt_st),
      .nxt_tag  (nxt_tag),
      .nxt_data (nxt_data),
      .st       (st),
      .tag      (tag),
      .data     (data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_accept;
         if (rd_accept) rsp_data <= rd_value;
      end
   end
endmodule

// File: rtl/snp_line_chk.sv
module snp_line_chk #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter bit WRITE_BACK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              bo_valid,
   input logic [1:0]        bo_kind,
   input logic [ADDR_W-1:0] bo_addr,
   input logic              sn_valid,
   input logic [1:0]        sn_kind,
   input logic              sup_valid
);
   AST_READ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && req_ready |=> rsp_valid); // R2
   AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write && req_ready) |=> !rsp_valid); // R3
   AST_BUS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bo_valid |-> req_valid); // R3
   AST_MISS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      bo_valid && bo_kind != 2'd2 |-> bo_addr == req_addr); // R2
   AST_STALL_WRITES_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |-> bo_valid && bo_kind == 2'd2 && bo_addr != req_addr); // R8
   AST_STALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && !req_ready) && req_valid |-> req_ready); // R8
   AST_SUPPLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      sup_valid |-> sn_valid && sn_kind == 2'd0); // R7
   AST_SUPPLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      sup_valid |=> !sup_valid); // R7

   generate
      if (WRITE_BACK) begin : g_wb_chk
         AST_INVAL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            bo_valid && bo_kind == 2'd1 |-> req_write); // R5
      end else begin : g_wt_chk
         AST_WT_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
            !sup_valid && req_ready); // R4
         AST_WT_WRITE_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid && req_write |-> bo_valid && bo_kind == 2'd2); // R4
      end
   endgenerate
endmodule

bind snp_line_ctrl snp_line_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_BACK(WRITE_BACK)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .bo_valid  (bo_valid),
   .bo_kind   (bo_kind),
   .bo_addr   (bo_addr),
   .sn_valid  (sn_valid),
   .sn_kind   (sn_kind),
   .sup_valid (sup_valid)
);

// File: tb/test_snp_line_ctrl.sv
module test_snp_line_ctrl;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam logic [AW-1:0] AX = 8'h20;
   localparam logic [AW-1:0] AY = 8'h44;
   localparam logic [AW-1:0] AZ = 8'h61;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid [2][2];
   logic          req_write [2][2];
   logic [AW-1:0] req_addr  [2][2];
   logic [DW-1:0] req_wdata [2][2];
   logic          req_ready [2][2];
   logic          rsp_valid [2][2];
   logic [DW-1:0] rsp_data  [2][2];
   logic          bo_valid  [2][2];
   logic [1:0]    bo_kind   [2][2];
   logic [AW-1:0] bo_addr   [2][2];
   logic [DW-1:0] bo_data   [2][2];
   logic [DW-1:0] bus_rdata [2][2];
   logic          sup_valid [2][2];
   logic [DW-1:0] sup_data  [2][2];
   logic [DW-1:0] mem [2];

   // pair 0 is write-through, pair 1 is write-back
   for (genvar p = 0; p < 2; p++) begin : g_pair
      for (genvar c = 0; c < 2; c++) begin : g_cache
         assign bus_rdata[p][c] = sup_valid[p][1-c] ? sup_data[p][1-c] : mem[p];
         snp_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_BACK(p == 1)) i_snp_line_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[p][c]),
            .req_write (req_write[p][c]),
            .req_addr  (req_addr[p][c]),
            .req_wdata (req_wdata[p][c]),
            .req_ready (req_ready[p][c]),
            .rsp_valid (rsp_valid[p][c]),
            .rsp_data  (rsp_data[p][c]),
            .bo_valid  (bo_valid[p][c]),
            .bo_kind   (bo_kind[p][c]),
            .bo_addr   (bo_addr[p][c]),
            .bo_data   (bo_data[p][c]),
            .bus_rdata (bus_rdata[p][c]),
            .sn_valid  (bo_valid[p][1-c]),
            .sn_kind   (bo_kind[p][1-c]),
            .sn_addr   (bo_addr[p][1-c]),
            .sup_valid (sup_valid[p][c]),
            .sup_data  (sup_data[p][c])
         );
      end
      always @(posedge clk) begin
         if (!rst_n) mem[p] <= 8'h07;
         else begin
            for (int c = 0; c < 2; c++) begin
               if (bo_valid[p][c] && bo_kind[p][c] == 2'd2) mem[p] <= bo_data[p][c];
               if (sup_valid[p][c]) mem[p] <= sup_data[p][c];
            end
         end
      end
   end

   // reference model: state 0 invalid, 1 clean, 2 modified
   int            m_st   [2][2];
   logic [AW-1:0] m_tag  [2][2];
   logic [DW-1:0] m_data [2][2];
   logic [DW-1:0] m_mem  [2];
   bit            x_rv   [2][2];
   logic [DW-1:0] x_rd   [2][2];
   bit            is_wb  [2] = '{1'b0, 1'b1};

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(bit ok, string tg, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tg, what, act, exp);
      end
   endtask

   task automatic step(int p, int c, bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
      bit            ev [2][2];
      int            ek [2][2];
      logic [AW-1:0] ea [2][2];
      logic [DW-1:0] ed [2][2];
      bit            er [2][2];
      bit            es [2][2];
      bit            eh [2][2];
      string         tg [2][2];
      int            o_st [2][2];
      logic [DW-1:0] o_data [2][2];
      logic [AW-1:0] o_tag [2][2];
      for (int pp = 0; pp < 2; pp++)
         for (int cc = 0; cc < 2; cc++) begin
            req_valid[pp][cc] = (pp == p && cc == c);
            req_write[pp][cc] = wr;
            req_addr[pp][cc]  = a;
            req_wdata[pp][cc] = d;
         end
      #1;
      for (int pp = 0; pp < 2; pp++)
         for (int cc = 0; cc < 2; cc++) begin
            ev[pp][cc] = 0; ek[pp][cc] = 0; ea[pp][cc] = '0; ed[pp][cc] = '0;
            er[pp][cc] = 1; es[pp][cc] = 0; tg[pp][cc] = "R9";
            eh[pp][cc] = (m_st[pp][cc] != 0) && (m_tag[pp][cc] == a);
            if (pp == p && cc == c) begin
               if (is_wb[pp] && m_st[pp][cc] == 2 && m_tag[pp][cc] != a) begin
                  tg[pp][cc] = "R8"; er[pp][cc] = 0; ev[pp][cc] = 1; ek[pp][cc] = 2;
                  ea[pp][cc] = m_tag[pp][cc]; ed[pp][cc] = m_data[pp][cc];
               end else if (!wr) begin
                  tg[pp][cc] = eh[pp][cc] ? "R3" : "R2";
                  if (!eh[pp][cc]) begin ev[pp][cc] = 1; ek[pp][cc] = 0; ea[pp][cc] = a; end
               end else if (!is_wb[pp]) begin
                  tg[pp][cc] = "R4"; ev[pp][cc] = 1; ek[pp][cc] = 2; ea[pp][cc] = a; ed[pp][cc] = d;
               end else begin
                  tg[pp][cc] = "R5";
                  if (!(m_st[pp][cc] == 2 && m_tag[pp][cc] == a)) begin
                     ev[pp][cc] = 1; ek[pp][cc] = 1; ea[pp][cc] = a;
                  end
               end
            end
         end
      for (int pp = 0; pp < 2; pp++)
         for (int cc = 0; cc < 2; cc++) begin
            int o = 1 - cc;
            if (ev[pp][o] && m_st[pp][cc] != 0 && m_tag[pp][cc] == ea[pp][o]) begin
               if (ek[pp][o] == 0) begin
                  if (m_st[pp][cc] == 2) begin es[pp][cc] = 1; tg[pp][cc] = "R7"; end
                  else tg[pp][cc] = "R10";
               end else tg[pp][cc] = "R6";
            end
         end
      for (int pp = 0; pp < 2; pp++) begin
         chk(mem[pp] == m_mem[pp], "R4 R7 R8", "memory", int'(mem[pp]), int'(m_mem[pp]));
         for (int cc = 0; cc < 2; cc++) begin
            chk(req_ready[pp][cc] == er[pp][cc], tg[pp][cc], "req_ready", int'(req_ready[pp][cc]), int'(er[pp][cc]));
            chk(bo_valid[pp][cc] == ev[pp][cc], tg[pp][cc], "bo_valid", int'(bo_valid[pp][cc]), int'(ev[pp][cc]));
            if (ev[pp][cc]) begin
               chk(int'(bo_kind[pp][cc]) == ek[pp][cc], tg[pp][cc], "bo_kind", int'(bo_kind[pp][cc]), ek[pp][cc]);
               chk(bo_addr[pp][cc] == ea[pp][cc], tg[pp][cc], "bo_addr", int'(bo_addr[pp][cc]), int'(ea[pp][cc]));
               if (ek[pp][cc] == 2)
                  chk(bo_data[pp][cc] == ed[pp][cc], tg[pp][cc], "bo_data", int'(bo_data[pp][cc]), int'(ed[pp][cc]));
            end
            chk(sup_valid[pp][cc] == es[pp][cc], tg[pp][cc], "sup_valid", int'(sup_valid[pp][cc]), int'(es[pp][cc]));
            if (es[pp][cc])
               chk(sup_data[pp][cc] == m_data[pp][cc], "R7", "sup_data", int'(sup_data[pp][cc]), int'(m_data[pp][cc]));
            chk(rsp_valid[pp][cc] == x_rv[pp][cc], "R2/R3", "rsp_valid", int'(rsp_valid[pp][cc]), int'(x_rv[pp][cc]));
            if (x_rv[pp][cc])
               chk(rsp_data[pp][cc] == x_rd[pp][cc], "R2/R3", "rsp_data", int'(rsp_data[pp][cc]), int'(x_rd[pp][cc]));
         end
      end
      @(posedge clk);
      o_st = m_st; o_tag = m_tag; o_data = m_data;
      for (int pp = 0; pp < 2; pp++)
         for (int cc = 0; cc < 2; cc++) begin
            int o = 1 - cc;
            x_rv[pp][cc] = 0;
            if (pp == p && cc == c) begin
               if (!er[pp][cc]) m_st[pp][cc] = 1;
               else if (!wr) begin
                  logic [DW-1:0] fill;
                  fill = es[pp][o] ? o_data[pp][o] : m_mem[pp];
                  x_rv[pp][cc] = 1;
                  x_rd[pp][cc] = eh[pp][cc] ? o_data[pp][cc] : fill;
                  if (!eh[pp][cc]) begin
                     m_st[pp][cc] = 1; m_tag[pp][cc] = a; m_data[pp][cc] = fill;
                  end
               end else begin
                  m_st[pp][cc] = is_wb[pp] ? 2 : 1; m_tag[pp][cc] = a; m_data[pp][cc] = d;
               end
            end
            if (ev[pp][o] && o_st[pp][cc] != 0 && o_tag[pp][cc] == ea[pp][o])
               m_st[pp][cc] = (ek[pp][o] == 0) ? ((o_st[pp][cc] == 2) ? 1 : o_st[pp][cc]) : 0;
            if (ev[pp][cc] && ek[pp][cc] == 2) m_mem[pp] = ed[pp][cc];
            if (es[pp][cc]) m_mem[pp] = o_data[pp][cc];
         end
      @(negedge clk);
   endtask

   task automatic access(int p, int c, bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
      bit stall;
      do begin
         stall = is_wb[p] && m_st[p][c] == 2 && m_tag[p][c] != a;
         step(p, c, wr, a, d);
      end while (stall);
   endtask

   task automatic run_seq(int p);
      access(p, 0, 0, AX, 8'h00);  // miss from memory
      access(p, 1, 0, AX, 8'h00);  // second sharer
      access(p, 0, 0, AX, 8'h00);  // hit
      access(p, 0, 1, AX, 8'h01);  // write to shared line
      access(p, 1, 0, AX, 8'h00);  // miss, dirty owner supplies (write-back)
      access(p, 0, 1, AX, 8'h06);
      access(p, 0, 1, AX, 8'h09);  // write to modified line
      access(p, 1, 1, AX, 8'h05);  // drops other modified copy
      access(p, 0, 0, AX, 8'h00);
      access(p, 0, 1, AX, 8'h04);
      access(p, 0, 0, AY, 8'h00);  // dirty victim evicted
      access(p, 1, 0, AY, 8'h00);
      access(p, 1, 1, AZ, 8'h02);  // snoop to other address
      access(p, 0, 0, AY, 8'h00);
      access(p, 0, 0, AZ, 8'h00);
      step(p, -1, 1'b0, '0, '0);
      step(p, -1, 1'b0, '0, '0);
   endtask

   initial begin
      for (int pp = 0; pp < 2; pp++) begin
         m_mem[pp] = 8'h07;
         for (int cc = 0; cc < 2; cc++) begin
            m_st[pp][cc] = 0; m_tag[pp][cc] = '0; m_data[pp][cc] = '0;
            x_rv[pp][cc] = 0; x_rd[pp][cc] = '0;
            req_valid[pp][cc] = 0; req_write[pp][cc] = 0;
            req_addr[pp][cc] = '0; req_wdata[pp][cc] = '0;
         end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int pp = 0; pp < 2; pp++)
         for (int cc = 0; cc < 2; cc++) begin
            chk(req_ready[pp][cc] == 1'b1, "R1", "req_ready", int'(req_ready[pp][cc]), 1);
            chk(bo_valid[pp][cc] == 1'b0, "R1", "bo_valid", int'(bo_valid[pp][cc]), 0);
            chk(rsp_valid[pp][cc] == 1'b0, "R1", "rsp_valid", int'(rsp_valid[pp][cc]), 0);
            chk(sup_valid[pp][cc] == 1'b0, "R1", "sup_valid", int'(sup_valid[pp][cc]), 0);
         end
      run_seq(0);
      run_seq(1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule